// File: doc/BRIEF.md
# Byte Packing Data Buffer

This block is a four-byte shift store that sits between a 16-bit host data port and a byte-wide serial engine. On the transmit path the host loads halfwords, or a lone final byte, and the engine drains them one byte at a time, oldest first. On the receive path the engine deposits bytes one at a time and the host collects them as halfwords. A single swap input picks which byte of a host halfword is the earlier one on the wire.

Transmit and receive keep separate byte counts over the same storage. The block raises the transmit-ready, receive-ready, transmit-underflow, receive-overrun and lone-byte flags that a control engine or an interrupt stage around it would consume. Only one operation takes effect per cycle. A fixed priority picks it: host write, then host read, then engine pop, then engine push.

Top module: `byte_pack_buf`

## Requirements
- R1: After reset both levels are 0, every flag is 0 and `host_rd_data` reads 0x0000.
- R2: An accepted halfword write raises `tx_level` by 2. With `swap_en`=0 the engine receives `host_wr_data[7:0]` before `host_wr_data[15:8]`. With `swap_en`=1 it receives `host_wr_data[15:8]` first.
- R3: An accepted byte write (`host_wr_byte`=1) raises `tx_level` by 1 and queues `host_wr_data[7:0]` as the newest byte.
- R4: A host write while `tx_level` is above 2 is dropped: level, queued bytes and flags stay as they were.
- R5: Every accepted host write clears `tx_udf`. It clears `tx_rdy` when the new level is above 2. An engine pop that leaves 2 or fewer bytes sets `tx_rdy`.
- R6: `eng_tx_byte` always shows the oldest queued byte, and a pop lowers `tx_level` by 1. A pop at level 0 sets `tx_udf` and changes no level.
- R7: An engine push below level 4 stores the byte in the next free position upward from bit 0, raises `rx_level` by 1 and sets `rx_rdy`. A push at level 4 sets `rx_ovr` and is dropped.
- R8: `host_rd_data` shows the two lowest stored bytes. With `swap_en`=0 the older byte is in bits [7:0]. With `swap_en`=1 the older byte is in bits [15:8].
- R9: A read at `rx_level` 1 sets `sbd_flag`, sets the level to 0 and clears `rx_rdy`. A pulse on `sbd_clr` clears `sbd_flag`, but a lone-byte read in the same cycle wins.
- R10: A read at `rx_level` 2 or more lowers it by 2. The store moves down by two bytes only when more than 2 bytes were held.
- R11: Every host read clears `rx_ovr`, and a read that brings the level to 0 clears `rx_rdy`. A read at level 0 changes nothing else, and `host_rd_data` keeps its value.
- R12: Per cycle only one of host write, host read, engine pop and engine push is acted on, in that priority order. The others are ignored in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_en | input | 1 | Selects the byte order of host halfwords |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_byte | input | 1 | 1: the write carries one byte, 0: a halfword |
| host_wr_data | input | 16 | Host write value |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_data | output | 16 | Two lowest stored bytes, ordered by `swap_en` |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_byte | output | 8 | Oldest queued transmit byte (0 when empty) |
| eng_rx_push | input | 1 | Engine delivers one received byte |
| eng_rx_byte | input | 8 | Received byte |
| sbd_clr | input | 1 | Clears the lone-byte flag |
| tx_level | output | 3 | Transmit bytes pending |
| rx_level | output | 3 | Receive bytes held |
| tx_rdy | output | 1 | Transmit side can take another halfword |
| rx_rdy | output | 1 | Received data is waiting |
| tx_udf | output | 1 | Engine popped from an empty transmit queue |
| rx_ovr | output | 1 | Engine pushed into a full receive store |
| sbd_flag | output | 1 | A read found one lone byte |

## Verification
Unswapped halfwords, swapped halfwords and a trailing byte write are sent through the transmit path, and a scoreboard follows the order in which the engine sees the bytes. Two distinct bytes per halfword show whether the swap is applied on the correct side. Receive reads are tried at levels 1, 2, 3 and 4, which separates the lone-byte path, the no-shift drain and the shift-down path. Overfull writes and pushes, a pop from an empty queue, an empty read and requests that collide in one cycle confirm that a dropped operation disturbs neither levels nor data.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_B = 2;
  localparam int unsigned HALF_W = BYTE_W * HALF_B;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_WR_HALF,
    OP_WR_BYTE,
    OP_RD,
    OP_POP,
    OP_PUSH
  } buf_op_e;

  // Order a host halfword so that the older byte lands in the upper position.
  function automatic logic [HALF_W-1:0] pack_half(input logic [HALF_W-1:0] d,
                                                   input logic swap);
    return swap ? d : {d[BYTE_W-1:0], d[HALF_W-1:BYTE_W]};
  endfunction

  // Present the two lowest stored bytes (older in bits [7:0]) in host order.
  function automatic logic [HALF_W-1:0] unpack_half(input logic [HALF_W-1:0] lo,
                                                     input logic swap);
    return swap ? {lo[BYTE_W-1:0], lo[HALF_W-1:BYTE_W]} : lo;
  endfunction

endpackage

// File: rtl/pbuf_arbiter.sv
module pbuf_arbiter
  import pbuf_pkg::*;
(
  input  logic    wr_en,
  input  logic    wr_byte,
  input  logic    rd_en,
  input  logic    pop,
  input  logic    push,
  output buf_op_e op
);

  always_comb begin
    if (wr_en)     op = wr_byte ? OP_WR_BYTE : OP_WR_HALF;
    else if (rd_en) op = OP_RD;
    else if (pop)   op = OP_POP;
    else if (push)  op = OP_PUSH;
    else            op = OP_IDLE;
  end

endmodule

// File: rtl/pbuf_tx_ctrl.sv
module pbuf_tx_ctrl
  import pbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  buf_op_e                        op,
  output logic [$clog2(DEPTH+1)-1:0]     level,
  output logic                           rdy,
  output logic                           udf,
  output logic                           wr_ok,
  output logic                           pop_ok,
  output logic                           udf_evt
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] ROOM = CNT_W'(DEPTH - HALF_B);

  logic             is_wr;
  logic [CNT_W-1:0] inc;
  logic [CNT_W-1:0] lvl_up;
  logic [CNT_W-1:0] lvl_dn;

  assign is_wr   = (op == OP_WR_HALF) || (op == OP_WR_BYTE);
  assign wr_ok   = is_wr && (level <= ROOM);
  assign inc     = (op == OP_WR_HALF) ? CNT_W'(HALF_B) : CNT_W'(1);
  assign lvl_up  = level + inc;
  assign lvl_dn  = level - CNT_W'(1);
  assign pop_ok  = (op == OP_POP) && (level != '0);
  assign udf_evt = (op == OP_POP) && (level == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= '0;
      rdy   <= 1'b0;
      udf   <= 1'b0;
    end else begin
      if (wr_ok) begin
        level <= lvl_up;
        udf   <= 1'b0;
        if (lvl_up > ROOM) rdy <= 1'b0;
      end else if (pop_ok) begin
        level <= lvl_dn;
        if (lvl_dn <= ROOM) rdy <= 1'b1;
      end else if (udf_evt) begin
        udf <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pbuf_rx_ctrl.sv
module pbuf_rx_ctrl
  import pbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  buf_op_e                        op,
  input  logic                           sbd_clr,
  output logic [$clog2(DEPTH+1)-1:0]     level,
  output logic                           rdy,
  output logic                           ovr,
  output logic                           sbd,
  output logic                           push_ok,
  output logic                           rd_single,
  output logic                           rd_shift
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] PAIR = CNT_W'(HALF_B);

  logic is_rd;
  logic rd_pair;
  logic ovr_evt;

  assign is_rd     = (op == OP_RD);
  assign rd_single = is_rd && (level == CNT_W'(1));
  assign rd_pair   = is_rd && (level >= PAIR);
  assign rd_shift  = is_rd && (level > PAIR);
  assign push_ok   = (op == OP_PUSH) && (level < FULL);
  assign ovr_evt   = (op == OP_PUSH) && (level == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= '0;
      rdy   <= 1'b0;
      ovr   <= 1'b0;
      sbd   <= 1'b0;
    end else begin
      if (sbd_clr) sbd <= 1'b0;
      if (is_rd) ovr <= 1'b0;
      if (rd_single) begin
        level <= '0;
        sbd   <= 1'b1;
        rdy   <= 1'b0;
      end else if (rd_pair) begin
        level <= level - PAIR;
        if (level == PAIR) rdy <= 1'b0;
      end else if (push_ok) begin
        level <= level + CNT_W'(1);
        rdy   <= 1'b1;
      end else if (ovr_evt) begin
        ovr <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pbuf_store.sv
module pbuf_store
  import pbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  buf_op_e                        op,
  input  logic                           wr_ok,
  input  logic                           push_ok,
  input  logic                           rd_shift,
  input  logic                           swap,
  input  logic [HALF_W-1:0]              wr_data,
  input  logic [BYTE_W-1:0]              rx_byte,
  input  logic [$clog2(DEPTH+1)-1:0]     rx_level,
  output logic [DEPTH*BYTE_W-1:0]        data
);

  localparam int unsigned W = DEPTH * BYTE_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0;
    end else begin
      if (wr_ok && op == OP_WR_HALF)
        data <= {data[W-HALF_W-1:0], pack_half(wr_data, swap)};
      else if (wr_ok && op == OP_WR_BYTE)
        data <= {data[W-BYTE_W-1:0], wr_data[BYTE_W-1:0]};
      else if (rd_shift)
        data <= data >> HALF_W;
      else if (push_ok)
        data[rx_level*BYTE_W +: BYTE_W] <= rx_byte;
    end
  end

endmodule

// File: rtl/byte_pack_buf.sv
module byte_pack_buf
  import pbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          swap_en,
  input  logic                          host_wr_en,
  input  logic                          host_wr_byte,
  input  logic [15:0]                   host_wr_data,
  input  logic                          host_rd_en,
  output logic [15:0]                   host_rd_data,
  input  logic                          eng_tx_pop,
  output logic [7:0]                    eng_tx_byte,
  input  logic                          eng_rx_push,
  input  logic [7:0]                    eng_rx_byte,
  input  logic                          sbd_clr,
  output logic [$clog2(DEPTH+1)-1:0]    tx_level,
  output logic [$clog2(DEPTH+1)-1:0]    rx_level,
  output logic                          tx_rdy,
  output logic                          rx_rdy,
  output logic                          tx_udf,
  output logic                          rx_ovr,
  output logic                          sbd_flag
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned W     = DEPTH * BYTE_W;

  buf_op_e          op;
  logic             wr_ok;
  logic             pop_ok;
  logic             udf_evt;
  logic             push_ok;
  logic             rd_single;
  logic             rd_shift;
  logic [W-1:0]     store;
  logic [CNT_W-1:0] tx_top;

  pbuf_arbiter u_arb (
    .wr_en   (host_wr_en),
    .wr_byte (host_wr_byte),
    .rd_en   (host_rd_en),
    .pop     (eng_tx_pop),
    .push    (eng_rx_push),
    .op      (op)
  );

  pbuf_tx_ctrl #(.DEPTH(DEPTH)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .level   (tx_level),
    .rdy     (tx_rdy),
    .udf     (tx_udf),
    .wr_ok   (wr_ok),
    .pop_ok  (pop_ok),
    .udf_evt (udf_evt)
  );

  pbuf_rx_ctrl #(.DEPTH(DEPTH)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .sbd_clr   (sbd_clr),
    .level     (rx_level),
    .rdy       (rx_rdy),
    .ovr       (rx_ovr),
    .sbd       (sbd_flag),
    .push_ok   (push_ok),
    .rd_single (rd_single),
    .rd_shift  (rd_shift)
  );

  pbuf_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .wr_ok    (wr_ok),
    .push_ok  (push_ok),
    .rd_shift (rd_shift),
    .swap     (swap_en),
    .wr_data  (host_wr_data),
    .rx_byte  (eng_rx_byte),
    .rx_level (rx_level),
    .data     (store)
  );

  assign tx_top       = tx_level - CNT_W'(1);
  assign eng_tx_byte  = (tx_level == '0) ? '0 : store[tx_top*BYTE_W +: BYTE_W];
  assign host_rd_data = unpack_half(store[HALF_W-1:0], swap_en);

endmodule

// File: rtl/pbuf_checker.sv
module pbuf_checker #(
  parameter int unsigned DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       host_wr_en,
  input logic                       host_wr_byte,
  input logic                       host_rd_en,
  input logic                       eng_tx_pop,
  input logic                       eng_rx_push,
  input logic                       sbd_clr,
  input logic [$clog2(DEPTH+1)-1:0] tx_level,
  input logic [$clog2(DEPTH+1)-1:0] rx_level,
  input logic                       tx_rdy,
  input logic                       rx_rdy,
  input logic                       tx_udf,
  input logic                       rx_ovr,
  input logic                       sbd_flag,
  input logic                       wr_ok,
  input logic                       push_ok
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= CNT_W'(DEPTH)); // R6

  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= CNT_W'(DEPTH)); // R7

  AST_HALF_ADDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_en && !host_wr_byte && tx_level <= CNT_W'(DEPTH-2)
    |=> tx_level == $past(tx_level) + CNT_W'(2)); // R2

  AST_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_en && tx_level > CNT_W'(DEPTH-2) |=> $stable(tx_level)); // R4

  AST_WR_CLEARS_UDF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !tx_udf); // R5

  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tx_pop && !host_wr_en && !host_rd_en && tx_level == '0
    |=> tx_udf && tx_level == '0); // R6

  AST_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_push && !host_wr_en && !host_rd_en && !eng_tx_pop
    && rx_level == CNT_W'(DEPTH) |=> rx_ovr && $stable(rx_level)); // R7

  AST_LONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_en && !host_wr_en && rx_level == CNT_W'(1)
    |=> sbd_flag && rx_level == '0 && !rx_rdy); // R9

  AST_RD_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_en && !host_wr_en |=> !rx_ovr); // R11

  AST_RX_RDY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rdy == (rx_level != '0)); // R7

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_ok, push_ok}) <= 1); // R12

  AST_TX_RDY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level > CNT_W'(DEPTH-2) |-> !tx_rdy); // R5

endmodule

bind byte_pack_buf pbuf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_wr_en   (host_wr_en),
  .host_wr_byte (host_wr_byte),
  .host_rd_en   (host_rd_en),
  .eng_tx_pop   (eng_tx_pop),
  .eng_rx_push  (eng_rx_push),
  .sbd_clr      (sbd_clr),
  .tx_level     (tx_level),
  .rx_level     (rx_level),
  .tx_rdy       (tx_rdy),
  .rx_rdy       (rx_rdy),
  .tx_udf       (tx_udf),
  .rx_ovr       (rx_ovr),
  .sbd_flag     (sbd_flag),
  .wr_ok        (wr_ok),
  .push_ok      (push_ok)
);

// File: tb/test_byte_pack_buf.sv
`timescale 1ns/1ps
module test_byte_pack_buf;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        swap_en = 1'b0;
  logic        host_wr_en = 1'b0;
  logic        host_wr_byte = 1'b0;
  logic [15:0] host_wr_data = '0;
  logic        host_rd_en = 1'b0;
  logic [15:0] host_rd_data;
  logic        eng_tx_pop = 1'b0;
  logic [7:0]  eng_tx_byte;
  logic        eng_rx_push = 1'b0;
  logic [7:0]  eng_rx_byte = '0;
  logic        sbd_clr = 1'b0;
  logic [2:0]  tx_level;
  logic [2:0]  rx_level;
  logic        tx_rdy, rx_rdy, tx_udf, rx_ovr, sbd_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  byte_pack_buf i_byte_pack_buf (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: each accepted engine pop must deliver the queue head.
  always @(negedge clk) begin
    if (rst_n && eng_tx_pop && !host_wr_en && !host_rd_en && tx_level != 0) begin
      if (exp_q.size() == 0) check("R6 unexpected pop", {24'h0, eng_tx_byte}, 32'hxx);
      else check("R6 pop order", {24'h0, eng_tx_byte}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_half(input logic [15:0] d, input logic sw, input bit expect_ok);
    swap_en = sw; host_wr_en = 1'b1; host_wr_byte = 1'b0; host_wr_data = d;
    if (expect_ok) begin
      if (sw) begin exp_q.push_back(d[15:8]); exp_q.push_back(d[7:0]); end
      else    begin exp_q.push_back(d[7:0]);  exp_q.push_back(d[15:8]); end
    end
    step();
    host_wr_en = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] d, input bit expect_ok);
    host_wr_en = 1'b1; host_wr_byte = 1'b1; host_wr_data = {8'hEE, d};
    if (expect_ok) exp_q.push_back(d);
    step();
    host_wr_en = 1'b0; host_wr_byte = 1'b0;
  endtask

  task automatic pop();
    eng_tx_pop = 1'b1; step(); eng_tx_pop = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    eng_rx_push = 1'b1; eng_rx_byte = b; step(); eng_rx_push = 1'b0;
  endtask

  task automatic rd(input logic sw, output logic [15:0] got);
    swap_en = sw; host_rd_en = 1'b1;
    @(negedge clk); got = host_rd_data;
    step(); host_rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    step(); step();
    // R1: reset state
    check("R1 tx_level", tx_level, 0);
    check("R1 rx_level", rx_level, 0);
    check("R1 flags", {tx_rdy, rx_rdy, tx_udf, rx_ovr, sbd_flag}, 0);
    check("R1 rd_data", host_rd_data, 0);
    rst_n = 1'b1; step();

    // R2: unswapped halfwords, level +2 each
    wr_half(16'h1234, 1'b0, 1);
    check("R2 level after one half", tx_level, 2);
    check("R2 oldest byte low", eng_tx_byte, 8'h34);
    wr_half(16'hABCD, 1'b0, 1);
    check("R5 level 4 clears rdy", {tx_level, tx_rdy}, {3'd4, 1'b0});
    // R4: write at level 4 dropped
    wr_byte(8'h99, 0);
    wr_half(16'h5555, 1'b0, 0);
    check("R4 dropped write level", tx_level, 4);
    pop(); pop();
    check("R5 pop to 2 sets rdy", {tx_level, tx_rdy}, {3'd2, 1'b1});
    pop(); pop();
    check("R6 drained", tx_level, 0);
    pop();
    check("R6 empty pop underflow", {tx_level, tx_udf}, {3'd0, 1'b1});
    // R3: byte write, then swapped halfword
    wr_byte(8'h5A, 1);
    check("R3 byte write level", tx_level, 1);
    check("R5 write clears udf", tx_udf, 0);
    wr_half(16'h7788, 1'b1, 1);
    check("R2 swapped level 3", tx_level, 3);
    check("R4 level 3 rejects byte", tx_level, 3);
    wr_byte(8'h11, 0);
    check("R4 level 3 dropped", tx_level, 3);
    pop(); pop(); pop();
    check("R2 scoreboard empty", exp_q.size(), 0);

    // R7, R8, R10: receive three bytes
    push(8'h11); push(8'h22); push(8'h33);
    check("R7 rx level and rdy", {rx_level, rx_rdy}, {3'd3, 1'b1});
    rd(1'b0, r);
    check("R8 unswapped read", r, 16'h2211);
    check("R10 level after read of 3", rx_level, 1);
    check("R10 shifted low byte", host_rd_data[7:0], 8'h33);
    // R9: lone byte
    rd(1'b0, r);
    check("R9 lone byte flags", {rx_level, rx_rdy, sbd_flag}, {3'd0, 1'b0, 1'b1});
    sbd_clr = 1'b1; step(); sbd_clr = 1'b0;
    check("R9 sbd cleared", sbd_flag, 0);

    // R7 overrun, R8 swap, R11 overrun clear
    push(8'hA1); push(8'hA2); push(8'hA3); push(8'hA4);
    push(8'hA5);
    check("R7 overrun", {rx_level, rx_ovr}, {3'd4, 1'b1});
    rd(1'b1, r);
    check("R8 swapped read", r, 16'hA1A2);
    check("R11 read clears ovr", {rx_level, rx_ovr}, {3'd2, 1'b0});
    rd(1'b1, r);
    check("R7 dropped push kept A3A4", r, 16'hA3A4);
    check("R11 empty clears rdy", {rx_level, rx_rdy}, {3'd0, 1'b0});

    // R10: exactly two bytes, no shift; R11: empty read keeps state
    push(8'hB1); push(8'hB2);
    rd(1'b0, r);
    check("R10 pair read", r, 16'hB2B1);
    check("R10 level 0", rx_level, 0);
    rd(1'b0, r);
    check("R11 empty read data held", r, 16'hB2B1);
    check("R11 empty read state", {rx_level, rx_rdy, sbd_flag, tx_level}, 0);

    // R12: write and push together; only the write acts
    host_wr_en = 1'b1; host_wr_data = 16'h0102; swap_en = 1'b0;
    eng_rx_push = 1'b1; eng_rx_byte = 8'h99;
    exp_q.push_back(8'h02); exp_q.push_back(8'h01);
    step();
    host_wr_en = 1'b0; eng_rx_push = 1'b0;
    check("R12 write wins over push", {tx_level, rx_level}, {3'd2, 3'd0});
    // R12: read and pop together; pop ignored
    host_rd_en = 1'b1; eng_tx_pop = 1'b1; step();
    host_rd_en = 1'b0; eng_tx_pop = 1'b0;
    check("R12 read wins over pop", tx_level, 2);
    pop(); pop();
    check("R12 scoreboard drained", exp_q.size(), 0);

    step();
    finish_run();
  end

endmodule